// File: doc/BRIEF.md
# Grouped Laser-Spreading Crossbar Controller

This block sequences the electronic crossbars of a two-stage grouped switch fabric. The fabric has G groups of L linecards, and every linecard is present. Inside each group, an input crossbar steers each linecard onto one of G fixed-wavelength lasers. Laser k of every group feeds a static center switch, and that switch always lands on the group k places further on, wrapping modulo G. At the far side, an output crossbar hands the arriving cells to the group's L linecards.

The controller keeps one slot counter with a period of L·G slots. For each linecard it produces the laser that linecard drives in the current slot. A linecard stays on one laser for a burst of L slots and then moves to the next laser, visiting all G lasers in turn. Linecards of the same group are staggered by their index, so they never share a laser. The controller also gives the group that each laser reaches, and for every receiving group and center switch it says whether a cell is arriving and which local linecard gets it.

Over one full period, every source linecard sends exactly one cell to every destination linecard, which gives equal-rate paths between all pairs. The scheme needs L ≤ G.

Top module: `lb_spread_ctrl`

## Requirements
- R1: Under reset the slot index is 0. After reset it rises by one on every clock and returns to 0 after slot L·G−1.
- R2: In slot s, linecard l of every group drives laser (floor(s/L) + l) mod G. The field for group g, linecard l is `lc_laser_o[(g*L+l)*KW +: KW]`.
- R3: Within one group in one slot, the L linecards drive L distinct lasers.
- R4: Laser k of sending group g reaches group (g + k) mod G, with 0-based indices, so laser 0 loops back to the sending group. The field is `laser_grp_o[(g*G+k)*KW +: KW]`.
- R5: In slot s, center switch k at a receiving group carries a cell exactly when src = (k − floor(s/L)) mod G is below L. That src is the sending linecard's index in its own group. The valid flag is bit `rx_valid_o[h*G+k]`, and exactly L flags per receiving group are set in each slot.
- R6: A valid arrival on center switch k goes to local linecard (src + s mod L) mod L. The field is `rx_lc_o[(h*G+k)*LW +: LW]`. In each slot, the L arrivals at a group go to L distinct linecards.
- R7: Over any one period of L·G slots, each source linecard (g,l) delivers exactly one cell to each destination linecard (h,m).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_o | output | SW | Current slot index, 0 to L·G−1 |
| lc_laser_o | output | G·L·KW | Laser chosen by each linecard of each group |
| laser_grp_o | output | G·G·KW | Receiving group reached by each laser of each group |
| rx_valid_o | output | G·G | Cell arriving on each center switch at each receiving group |
| rx_lc_o | output | G·G·LW | Local destination linecard for each arrival |

## Verification
The assertions check the following on every cycle:
- the counter steps and wraps correctly;
- each laser is held for a whole burst and then advances by one;
- lasers within a group never collide;
- every laser in use is matched by an arrival at the group it reaches;
- each receiving group sees exactly L arrivals, and they go to L distinct linecards.

Some properties only the bench's scenarios can show, because each spans a whole period:
- the exact laser sequence against a stimulus table;
- the identity of each arriving cell's source;
- that each of the (L·G)² linecard pairs is served exactly once per period;
- the counter's return to slot 0 when reset is applied mid-period.

// File: rtl/lb_spread_ctrl.sv
module lb_spread_ctrl #(
  parameter int G = 4,
  parameter int L = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  output logic [((G*L > 1) ? $clog2(G*L) : 1)-1:0]  slot_o,
  output logic [G*L*((G > 1) ? $clog2(G) : 1)-1:0]  lc_laser_o,
  output logic [G*G*((G > 1) ? $clog2(G) : 1)-1:0]  laser_grp_o,
  output logic [G*G-1:0]                            rx_valid_o,
  output logic [G*G*((L > 1) ? $clog2(L) : 1)-1:0]  rx_lc_o
);
  localparam int KW  = (G > 1) ? $clog2(G) : 1;
  localparam int LW  = (L > 1) ? $clog2(L) : 1;
  localparam int PER = G * L;
  localparam int SW  = (PER > 1) ? $clog2(PER) : 1;

  logic [KW-1:0] burst;
  logic [LW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst <= '0;
      pos   <= '0;
    end else if (pos == LW'(L-1)) begin
      pos   <= '0;
      burst <= (burst == KW'(G-1)) ? '0 : burst + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assign slot_o = SW'(int'(burst) * L + int'(pos));

  for (genvar g = 0; g < G; g++) begin : g_send
    for (genvar l = 0; l < L; l++) begin : g_lc
      logic [KW:0] sum;
      assign sum = {1'b0, burst} + (KW+1)'(l);
      assign lc_laser_o[(g*L+l)*KW +: KW] =
        KW'((sum >= (KW+1)'(G)) ? sum - (KW+1)'(G) : sum);
    end
    for (genvar k = 0; k < G; k++) begin : g_las
      assign laser_grp_o[(g*G+k)*KW +: KW] = KW'((g + k) % G);
    end
  end

  for (genvar h = 0; h < G; h++) begin : g_recv
    for (genvar k = 0; k < G; k++) begin : g_cs
      logic [KW:0] diff;
      logic [KW:0] src;
      logic [KW:0] sm;
      assign diff = (KW+1)'(k + G) - {1'b0, burst};
      assign src  = (diff >= (KW+1)'(G)) ? diff - (KW+1)'(G) : diff;
      assign sm   = src + (KW+1)'(pos);
      assign rx_valid_o[h*G+k] = (src < (KW+1)'(L));
      assign rx_lc_o[(h*G+k)*LW +: LW] = rx_valid_o[h*G+k] ?
        LW'((sm >= (KW+1)'(L)) ? sm - (KW+1)'(L) : sm) : '0;
    end
  end
endmodule

// File: rtl/lb_spread_ctrl_chk.sv
module lb_spread_ctrl_chk #(
  parameter int G = 4,
  parameter int L = 3
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic [((G*L > 1) ? $clog2(G*L) : 1)-1:0]  slot_o,
  input logic [G*L*((G > 1) ? $clog2(G) : 1)-1:0]  lc_laser_o,
  input logic [G*G*((G > 1) ? $clog2(G) : 1)-1:0]  laser_grp_o,
  input logic [G*G-1:0]                            rx_valid_o,
  input logic [G*G*((L > 1) ? $clog2(L) : 1)-1:0]  rx_lc_o
);
  localparam int KW  = (G > 1) ? $clog2(G) : 1;
  localparam int LW  = (L > 1) ? $clog2(L) : 1;
  localparam int PER = G * L;
  localparam int SW  = (PER > 1) ? $clog2(PER) : 1;

  logic          burst_end;
  logic [G-1:0]  lmask [G];
  logic [L-1:0]  dmask [G];
  logic [G-1:0]  linked;

  assign burst_end = (int'(slot_o) % L) == (L - 1);

  always_comb begin
    for (int g = 0; g < G; g++) begin
      lmask[g]  = '0;
      linked[g] = 1'b1;
      for (int l = 0; l < L; l++) begin
        int k;
        int h;
        k = int'(lc_laser_o[(g*L+l)*KW +: KW]);
        h = int'(laser_grp_o[(g*G+k)*KW +: KW]);
        lmask[g][k] = 1'b1;
        if (!rx_valid_o[h*G+k]) linked[g] = 1'b0;
      end
    end
    for (int h = 0; h < G; h++) begin
      dmask[h] = '0;
      for (int k = 0; k < G; k++)
        if (rx_valid_o[h*G+k]) dmask[h][int'(rx_lc_o[(h*G+k)*LW +: LW])] = 1'b1;
    end
  end

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o == SW'(PER-1)) |=> (slot_o == '0));
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o != SW'(PER-1)) |=> (slot_o == $past(slot_o) + 1'b1));

  for (genvar i = 0; i < G*L; i++) begin : g_lane
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_end |=> $stable(lc_laser_o[i*KW +: KW]));
    a_r2_adv: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |=> (int'(lc_laser_o[i*KW +: KW]) ==
                     (int'($past(lc_laser_o[i*KW +: KW])) + 1) % G));
  end

  for (genvar g = 0; g < G; g++) begin : g_grp
    a_r3_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lmask[g]) == L);
    a_r5_linked: assert property (@(posedge clk) disable iff (!rst_n)
      linked[g]);
    a_r5_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rx_valid_o[g*G +: G]) == L);
    a_r6_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dmask[g]) == L);
  end
endmodule

bind lb_spread_ctrl lb_spread_ctrl_chk #(.G(G), .L(L)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_o(slot_o), .lc_laser_o(lc_laser_o),
  .laser_grp_o(laser_grp_o), .rx_valid_o(rx_valid_o), .rx_lc_o(rx_lc_o)
);

// File: tb/tb_lb_spread_ctrl.sv
module tb_lb_spread_ctrl;
  localparam int G = 4;
  localparam int L = 3;
  localparam int KW = 2;
  localparam int LW = 2;
  localparam int SW = 4;
  localparam int N = G * L;
  // {slot, laser of lc0, lc1, lc2}
  localparam logic [15:0] VEC [N] = '{
    16'h0012, 16'h1012, 16'h2012, 16'h3123, 16'h4123, 16'h5123,
    16'h6230, 16'h7230, 16'h8230, 16'h9301, 16'hA301, 16'hB301};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0]     slot_o;
  logic [G*L*KW-1:0] lc_laser_o;
  logic [G*G*KW-1:0] laser_grp_o;
  logic [G*G-1:0]    rx_valid_o;
  logic [G*G*LW-1:0] rx_lc_o;
  int n_chk = 0;
  int n_fail = 0;
  int hit [N*N];

  always #2 clk = ~clk;

  lb_spread_ctrl #(.G(G), .L(L)) dut (
    .clk(clk), .rst_n(rst_n), .slot_o(slot_o), .lc_laser_o(lc_laser_o),
    .laser_grp_o(laser_grp_o), .rx_valid_o(rx_valid_o), .rx_lc_o(rx_lc_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int laser(input int g, input int l);
    return int'(lc_laser_o[(g*L+l)*KW +: KW]);
  endfunction

  task automatic check_lasers(input logic [15:0] e, input string req);
    for (int g = 0; g < G; g++)
      for (int l = 0; l < L; l++) begin
        int ex;
        ex = int'(e[(2-l)*4 +: 4]);
        chk(laser(g, l) == ex, req, laser(g, l), ex);
      end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N*N; i++) hit[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(slot_o == 0, "R1 reset slot", int'(slot_o), 0);
    check_lasers(VEC[0], "R2 reset lasers");
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      chk(int'(slot_o) == int'(VEC[i][15:12]), "R1 step", int'(slot_o), int'(VEC[i][15:12]));
      check_lasers(VEC[i], "R2 laser table");
      for (int g = 0; g < G; g++) begin
        logic [G-1:0] m;
        m = '0;
        for (int l = 0; l < L; l++) m[laser(g, l)] = 1'b1;
        chk($countones(m) == L, "R3 distinct lasers", $countones(m), L);
      end
      for (int h = 0; h < G; h++) begin
        int cnt;
        logic [L-1:0] dm;
        cnt = 0;
        dm = '0;
        for (int k = 0; k < G; k++)
          if (rx_valid_o[h*G+k]) begin
            cnt++;
            dm[int'(rx_lc_o[(h*G+k)*LW +: LW])] = 1'b1;
          end
        chk(cnt == L, "R5 arrivals per group", cnt, L);
        chk(dm == '1, "R6 distinct destinations", int'(dm), (1 << L) - 1);
      end
      for (int g = 0; g < G; g++)
        for (int l = 0; l < L; l++) begin
          int k, h, src, m, em;
          k = laser(g, l);
          h = int'(laser_grp_o[(g*G+k)*KW +: KW]);
          chk(h == (g + k) % G, "R4 reached group", h, (g + k) % G);
          chk(rx_valid_o[h*G+k] == 1'b1, "R5 arrival valid", int'(rx_valid_o[h*G+k]), 1);
          src = (k - i / L + G) % G;
          chk(src == l, "R5 source linecard", src, l);
          m = int'(rx_lc_o[(h*G+k)*LW +: LW]);
          em = (l + i % L) % L;
          chk(m == em, "R6 destination linecard", m, em);
          hit[(g*L+l)*N + h*L + m]++;
        end
      @(negedge clk);
    end
    chk(slot_o == 0, "R1 wrap", int'(slot_o), 0);
    for (int p = 0; p < N*N; p++)
      chk(hit[p] == 1, "R7 pair served once", hit[p], 1);

    for (int g = 0; g < G; g++)
      for (int k = 0; k < G; k++)
        chk(int'(laser_grp_o[(g*G+k)*KW +: KW]) == (g + k) % G, "R4 static map",
            int'(laser_grp_o[(g*G+k)*KW +: KW]), (g + k) % G);

    repeat (5) @(negedge clk);
    chk(slot_o == 5, "R1 mid period", int'(slot_o), 5);
    rst_n = 1'b0;
    @(negedge clk);
    chk(slot_o == 0, "R1 mid-period reset", int'(slot_o), 0);
    check_lasers(VEC[0], "R2 after reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_o == 1, "R1 restart", int'(slot_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule